// File: doc/BRIEF.md
# Dual-Channel SPI Converter Sample Writer

This block moves one pair of audio samples into a two-channel 12-bit serial digital-to-analog converter each time a sample tick arrives. The two 16-bit samples are reduced to 12 bits by dropping their four least significant bits. Each one is then wrapped in a 16-bit command word whose top four bits select the channel, unity gain and the active state. The words go out as two separate SPI transactions. Channel A goes first, then channel B, and each has its own chip-select window. Raising chip select at the end of a window makes the converter latch that channel.

A per-channel enable picks between a normal write and a shutdown command for that channel. The transfer starts on the clock cycle right after the tick is taken, so the output update has a fixed, low-jitter relation to the sample tick. A tick that arrives while a transfer is in progress is dropped, and a sticky overrun flag records that it happened.

Top module: `dac_pair_sender`

## Requirements
- R1: For an enabled channel the frame is {ch, 0, 1, 1, sample[15:4]}, with ch = 0 for channel A and ch = 1 for channel B. Bit 15 holds ch, bits 11:0 hold the data.
- R2: For a disabled channel the frame is {ch, 0, 1, 0, 12'h000}. That is 16'h2000 for channel A and 16'hA000 for channel B.
- R3: Each accepted tick produces exactly two chip-select windows, channel A's frame in the first and channel B's frame in the second. Each window holds exactly 16 rising SCLK edges.
- R4: Bits go out MSB first in SPI mode 0. SCLK is low whenever chip select is high, and MOSI changes only while SCLK is low.
- R5: Within a frame, consecutive rising SCLK edges are exactly CLK_DIV system clock cycles apart.
- R6: Between the two frames of one tick, chip select stays high for at least CLK_DIV system cycles.
- R7: On the first clock edge after an idle block samples tick high, cs_n goes low and busy goes high.
- R8: busy stays high until channel B's frame and its trailing high-CS gap are complete. Whenever busy is low, cs_n is high.
- R9: A tick sampled while busy is high does not start or change any transfer. It sets overrun on the next edge, and overrun then stays high until reset.
- R10: After reset, cs_n is 1, sclk is 0, mosi is 0, busy is 0 and overrun is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample tick; starts a transfer when idle |
| sample_a_i | input | 16 | Channel A sample, taken when the tick is accepted |
| sample_b_i | input | 16 | Channel B sample, taken when the tick is accepted |
| en_a_i | input | 1 | 1 = write channel A, 0 = shut channel A down |
| en_b_i | input | 1 | 1 = write channel B, 0 = shut channel B down |
| sclk_o | output | 1 | SPI serial clock, idle low |
| mosi_o | output | 1 | SPI serial data, MSB first |
| cs_n_o | output | 1 | Active-low converter chip select |
| busy_o | output | 1 | High while a channel pair is being sent |
| overrun_o | output | 1 | Sticky flag: a tick arrived while busy |

## Verification
The assertions assume the inputs carry known values once reset is released. They also assume the samples and enables matter only in the cycle the tick is accepted. Nothing is assumed about how long the tick is held or how it is spaced, because a tick held through a busy period simply raises overrun.

The stimulus drives one-cycle ticks with random samples and enables, and starts each one only after busy has dropped. The single exception is a tick sent on purpose in the middle of a transfer, which exercises the drop-and-flag path. Samples and enables stay stable for the whole transfer, so the decoded frames can be compared directly with the words computed in the bench.

// File: rtl/dac_pair_pkg.sv
package dac_pair_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned DATA_BITS  = 12;
  localparam int unsigned NUM_CH     = 2;

  typedef logic [FRAME_BITS-1:0] frame_t;

  // Command word: {channel, unused 0, unity gain, active, 12-bit data}
  function automatic frame_t dac_cmd_word(input logic ch, input logic en,
                                          input logic [15:0] smp);
    logic [DATA_BITS-1:0] data;
    data = en ? smp[15:4] : '0;
    return {ch, 1'b0, 1'b1, en, data};
  endfunction
endpackage

// File: rtl/dac_frame_fmt.sv
module dac_frame_fmt
  import dac_pair_pkg::*;
(
  input  logic [NUM_CH-1:0][15:0] samples_i,
  input  logic [NUM_CH-1:0]       en_i,
  output frame_t [NUM_CH-1:0]     words_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign words_o[g] = dac_cmd_word(1'(g), en_i[g], samples_i[g]);
  end
endmodule

// File: rtl/dac_half_timer.sv
module dac_half_timer #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic half_end_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign half_end_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/dac_seq.sv
module dac_seq #(
  parameter int unsigned LAST_STEP = 34
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       half_end_i,
  output logic       busy_o,
  output logic       frame_o,
  output logic [5:0] step_o,
  output logic       accept_o,
  output logic       drop_o,
  output logic       pair_done_o,
  output logic       overrun_o
);
  logic frame_end;

  assign accept_o    = tick_i && !busy_o;
  assign drop_o      = tick_i && busy_o;
  assign frame_end   = half_end_i && (step_o == 6'(LAST_STEP));
  assign pair_done_o = frame_end && frame_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o    <= 1'b0;
      frame_o   <= 1'b0;
      step_o    <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (drop_o) overrun_o <= 1'b1;
      if (accept_o) begin
        busy_o  <= 1'b1;
        frame_o <= 1'b0;
        step_o  <= '0;
      end else if (frame_end) begin
        step_o <= '0;
        if (frame_o) busy_o  <= 1'b0;
        else         frame_o <= 1'b1;
      end else if (half_end_i) begin
        step_o <= step_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_pair_sender.sv
module dac_pair_sender
  import dac_pair_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic [15:0] sample_a_i,
  input  logic [15:0] sample_b_i,
  input  logic        en_a_i,
  input  logic        en_b_i,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        cs_n_o,
  output logic        busy_o,
  output logic        overrun_o
);
  localparam int unsigned HALF      = CLK_DIV / 2;
  localparam int unsigned BIT_STEPS = 2 * FRAME_BITS;   // high+low per bit
  localparam int unsigned LAST_STEP = BIT_STEPS + 2;    // + one SCLK period gap

  frame_t [NUM_CH-1:0] words_new, words_q;
  logic                half_end, frame_sel, tick_accept, tick_drop, pair_done;
  logic [5:0]          step;
  logic                in_window;
  logic [3:0]          bit_idx;

  dac_frame_fmt u_fmt (
    .samples_i ({sample_b_i, sample_a_i}),
    .en_i      ({en_b_i, en_a_i}),
    .words_o   (words_new)
  );

  dac_half_timer #(.HALF(HALF)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (busy_o),
    .half_end_o (half_end)
  );

  dac_seq #(.LAST_STEP(LAST_STEP)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .half_end_i  (half_end),
    .busy_o      (busy_o),
    .frame_o     (frame_sel),
    .step_o      (step),
    .accept_o    (tick_accept),
    .drop_o      (tick_drop),
    .pair_done_o (pair_done),
    .overrun_o   (overrun_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           words_q <= '0;
    else if (tick_accept) words_q <= words_new;
  end

  // Step 0: setup with CS low; odd steps 1..31 SCLK high; step 32 SCLK low;
  // steps 33..LAST_STEP: CS high gap.
  assign in_window = busy_o && (step <= 6'(BIT_STEPS));
  assign bit_idx   = ~step[4:1];
  assign cs_n_o    = !in_window;
  assign sclk_o    = in_window && step[0];
  assign mosi_o    = (busy_o && step < 6'(BIT_STEPS)) ? words_q[frame_sel][bit_idx] : 1'b0;

  initial begin
    if (CLK_DIV < 2 || (CLK_DIV % 2) != 0)
      $error("CLK_DIV must be even and at least 2");
  end
endmodule

// File: rtl/dac_pair_sender_chk.sv
module dac_pair_sender_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_n_o,
  input logic busy_o,
  input logic overrun_o,
  input logic tick_accept,
  input logic tick_drop,
  input logic pair_done
);
  p_sclk_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  p_mosi_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  p_start_next_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_accept |=> (!cs_n_o && busy_o));

  p_idle_cs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> cs_n_o);

  p_done_drops_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |=> !busy_o);

  p_drop_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_drop |=> overrun_o);

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  p_drop_keeps_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && busy_o && !pair_done) |=> busy_o);
endmodule

bind dac_pair_sender dac_pair_sender_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .cs_n_o      (cs_n_o),
  .busy_o      (busy_o),
  .overrun_o   (overrun_o),
  .tick_accept (tick_accept),
  .tick_drop   (tick_drop),
  .pair_done   (pair_done)
);

// File: tb/dac_pair_sender_bench.sv
module dac_pair_sender_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] sa = '0, sb = '0;
  logic        ea = 1'b0, eb = 1'b0;
  logic        sclk, mosi, cs_n, busy, overrun;

  int n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  dac_pair_sender #(.CLK_DIV(DIV)) u_dac_pair_sender (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .sample_a_i(sa), .sample_b_i(sb), .en_a_i(ea), .en_b_i(eb),
    .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n), .busy_o(busy), .overrun_o(overrun)
  );

  // ---------- SPI monitor ----------
  int          cyc = 0;
  logic [15:0] sh = '0;
  int          nb = 0, nf = 0, last_rise = -1, per_bad = 0, cs_rise_cyc = 0, gap = 0;
  logic [15:0] fw [4];
  int          fbits [4];
  int          mode_bad = 0;
  logic        prev_sclk = 1'b0, prev_mosi = 1'b0;

  always @(posedge clk) cyc++;

  always @(posedge sclk) if (!cs_n) begin
    sh = {sh[14:0], mosi};
    nb++;
    if (last_rise >= 0 && cyc - last_rise != DIV) per_bad++;
    last_rise = cyc;
  end

  always @(negedge cs_n) begin
    nb = 0;
    last_rise = -1;
    if (nf == 1) gap = cyc - cs_rise_cyc;
  end

  always @(posedge cs_n) if (rst_n) begin
    if (nf < 4) begin fw[nf] = sh; fbits[nf] = nb; end
    nf++;
    cs_rise_cyc = cyc;
  end

  always @(negedge clk) if (rst_n) begin
    if (cs_n && sclk) mode_bad++;
    if (sclk && prev_sclk && mosi !== prev_mosi) mode_bad++;
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  // ---------- helpers ----------
  function automatic logic [15:0] exp_word(input bit ch, input bit en, input logic [15:0] s);
    logic [15:0] w;
    w = en ? (16'h3000 | (s >> 4)) : 16'h2000;
    if (ch) w = w + 16'h8000;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<=150000", cyc);
    finish_run();
  end

  task automatic trial(input logic [15:0] a, input logic [15:0] b,
                       input bit ena, input bit enb, input bit extra);
    int waitc;
    @(negedge clk);
    sa = a; sb = b; ea = ena; eb = enb;
    nf = 0; per_bad = 0; mode_bad = 0; gap = 0;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R7 cs_n low after tick", cs_n, 0);
    check("R7 busy high after tick", busy, 1);
    if (extra) begin
      repeat (5) @(negedge clk);
      sa = ~a; sb = ~b; ea = ~ena; eb = ~enb;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      check("R9 overrun set", overrun, 1);
    end
    waitc = 0;
    while (busy && waitc < 1000) begin @(negedge clk); waitc++; end
    check("R8 busy ends", busy, 0);
    check("R8 cs_n high when idle", cs_n, 1);
    repeat (DIV * 3) @(negedge clk);
    check("R3 two frames per tick", nf, 2);
    check("R3 bits in frame A", fbits[0], 16);
    check("R3 bits in frame B", fbits[1], 16);
    check(ena ? "R1 frame A word" : "R2 frame A shutdown", fw[0], exp_word(0, ena, a));
    check(enb ? "R1 frame B word" : "R2 frame B shutdown", fw[1], exp_word(1, enb, b));
    check("R5 SCLK period", per_bad, 0);
    check("R6 CS gap", gap >= DIV, 1);
    check("R4 mode 0 timing", mode_bad, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 cs_n", cs_n, 1);
    check("R10 sclk", sclk, 0);
    check("R10 mosi", mosi, 0);
    check("R10 busy", busy, 0);
    check("R10 overrun", overrun, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    trial(16'hFFFF, 16'h0000, 1, 1, 0);
    trial(16'h000F, 16'hFFF0, 1, 1, 0);
    trial(16'h1234, 16'hABCD, 0, 0, 0);
    trial(16'h8001, 16'h7FFE, 1, 0, 0);
    trial(16'h5A5A, 16'hA5A5, 0, 1, 0);
    check("R9 overrun clear before drop", overrun, 0);

    // random traffic
    for (int i = 0; i < 40; i++)
      trial(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 0);

    // tick while busy: ignored, flag sticky
    trial(16'h4321, 16'h8765, 1, 1, 1);
    check("R9 overrun sticky", overrun, 1);
    trial(16'h0F0F, 16'hF0F0, 1, 0, 0);
    check("R9 overrun still set", overrun, 1);

    finish_run();
  end
endmodule